// File: doc/BRIEF.md
# Parallel-Lane XTS Block Encryptor

This block encrypts a batch of independent 16-byte blocks with the XTS XOR-encrypt-XOR construction on top of AES-256. Every lane has its own plaintext and its own tweak. All lanes advance through the cipher rounds together. A single round key per round is shared by all lanes: the block places a round number on its key-request port and reads the matching 128-bit expanded key back in that same cycle. Key expansion happens elsewhere. So do tweak sequencing and decryption.

A batch enters through a valid/ready handshake. The first step is a three-way XOR of plaintext, tweak and round key 0. The block then runs one cipher round per clock. Once the fourteenth round is done, each lane's tweak is XORed into its state once more to give the ciphertext. The result stays on the output until the consumer takes it, and the next batch cannot enter before that.

Top module: `xts_multilane_enc`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0 and `key_idx` is 0.
- R2: For each lane, the ciphertext equals AES-256(plaintext XOR tweak) XOR tweak, where the AES-256 key is given by the fifteen round keys presented on `round_key`.
- R3: A lane whose tweak is all zeros returns plain AES-256 of its plaintext. With the key bytes 00,01,...,1f and the plaintext 00112233445566778899aabbccddeeff, the result is 8ea2b7ca516745bfeafc49904b496089.
- R4: Lanes do not interact. Lane i uses bits [i*128+127 : i*128] of `in_data`, `in_tweak` and `out_data`, and its result depends only on its own inputs.
- R5: In the accept cycle `key_idx` is 0, and the key on `round_key` is applied as round key 0. In the k-th cycle after the accept edge (k = 1..14), `key_idx` equals k. In every other cycle it is 0.
- R6: `out_valid` first goes to 1 after the fifteenth rising edge that follows the accepting edge.
- R7: From the accept edge until the output has been taken, `in_ready` stays 0. While it is 0, `in_valid`, `in_data` and `in_tweak` have no effect on the batch in flight.
- R8: While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_data` hold their values.
- R9: After an edge where `out_valid` and `out_ready` are both 1, `out_valid` falls to 0 and `in_ready` rises to 1.
- R10: Byte 0 of a block or key is bits [127:120]. Bytes fill the state column by column, four bytes to a column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Batch offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_data | input | LANES*128 | Plaintext blocks, lane i in slice i |
| in_tweak | input | LANES*128 | Tweaks, lane i in slice i |
| key_idx | output | clog2(NR+1) | Round number whose key is wanted this cycle |
| round_key | input | 128 | Expanded round key for `key_idx`, same cycle |
| out_valid | output | 1 | Ciphertext batch available |
| out_ready | input | 1 | Consumer takes the batch |
| out_data | output | LANES*128 | Ciphertext blocks, lane i in slice i |

## Verification
The round index is due in the cycle after the accept edge and counts up by one per clock. Result-valid is due fifteen edges after the accepting edge. The ready line must be low at every sample in between. The bench drives inputs on falling edges and counts falling edges from the accept. At each one it compares `key_idx` with the expected round number and records the first falling edge at which `out_valid` is seen, so the check stays cycle-exact. Expected ciphertexts come from a single AES-256 known answer, reused across lanes by choosing plaintext = P XOR T, which makes each lane's ciphertext equal C XOR T. The ready-return check is sampled on the falling edge right after the output handshake edge.

// File: rtl/xts_pkg.sv
package xts_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_N = BLK_W / 8;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_WHITEN,
        PH_HOLD
    } phase_t;

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] sq;
        r  = 8'h01;
        sq = gf_mul(a, a);
        for (int i = 1; i < 8; i++) begin
            r  = gf_mul(r, sq);
            sq = gf_mul(sq, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
        return (b << k) | (b >> (8 - k));
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] byte_at(input blk_t x, input int n);
        return x[BLK_W-1-8*n -: 8];
    endfunction

    // substitution followed by row rotation; byte n = row (n%4), column (n/4)
    function automatic blk_t sub_shift(input blk_t x);
        blk_t y;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                y[BLK_W-1-8*(r+4*c) -: 8] = sub_byte(byte_at(x, r + 4*((c + r) % 4)));
            end
        end
        return y;
    endfunction

    function automatic blk_t mix_cols(input blk_t x);
        blk_t y;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < 4; c++) begin
            a0 = byte_at(x, 4*c);
            a1 = byte_at(x, 4*c + 1);
            a2 = byte_at(x, 4*c + 2);
            a3 = byte_at(x, 4*c + 3);
            y[BLK_W-1-8*(4*c)   -: 8] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
            y[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
            y[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
            y[BLK_W-1-8*(4*c+3) -: 8] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
        end
        return y;
    endfunction

endpackage

// File: rtl/xts_ctrl.sv
module xts_ctrl
    import xts_pkg::*;
#(
    parameter int NR    = 14,
    parameter int IDX_W = $clog2(NR + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             whiten,
    output logic [IDX_W-1:0] key_idx
);

    phase_t           phase_q;
    logic [IDX_W-1:0] cnt_q;

    always_comb begin
        in_ready  = (phase_q == PH_IDLE);
        out_valid = (phase_q == PH_HOLD);
        load      = (phase_q == PH_IDLE) && in_valid;
        step      = (phase_q == PH_RUN);
        last      = (cnt_q == IDX_W'(NR));
        whiten    = (phase_q == PH_WHITEN);
        key_idx   = (phase_q == PH_RUN) ? cnt_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (in_valid) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= IDX_W'(1);
                    end
                end
                PH_RUN: begin
                    if (cnt_q == IDX_W'(NR)) begin
                        phase_q <= PH_WHITEN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WHITEN: phase_q <= PH_HOLD;
                PH_HOLD: begin
                    if (out_ready) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xts_lane.sv
module xts_lane
    import xts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  logic last,
    input  logic whiten,
    input  blk_t pt,
    input  blk_t tw,
    input  blk_t rk,
    output blk_t ct
);

    blk_t st_q;
    blk_t tw_q;
    blk_t ct_q;
    blk_t shifted;
    blk_t mixed;
    blk_t nxt;

    always_comb begin
        shifted = sub_shift(st_q);
        mixed   = last ? shifted : mix_cols(shifted);
        nxt     = mixed ^ rk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            tw_q <= '0;
            ct_q <= '0;
        end else begin
            if (load) begin
                st_q <= pt ^ tw ^ rk;
                tw_q <= tw;
            end else if (step) begin
                st_q <= nxt;
            end
            if (whiten) ct_q <= st_q ^ tw_q;
        end
    end

    assign ct = ct_q;

endmodule

// File: rtl/xts_multilane_enc.sv
module xts_multilane_enc
    import xts_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NR    = 14,
    localparam int IDX_W = $clog2(NR + 1),
    localparam int BUS_W = LANES * BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BUS_W-1:0] in_data,
    input  logic [BUS_W-1:0] in_tweak,
    output logic [IDX_W-1:0] key_idx,
    input  logic [BLK_W-1:0] round_key,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BUS_W-1:0] out_data
);

    logic load, step, last, whiten;

    xts_ctrl #(.NR(NR), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .step      (step),
        .last      (last),
        .whiten    (whiten),
        .key_idx   (key_idx)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        blk_t lane_ct;
        xts_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .step   (step),
            .last   (last),
            .whiten (whiten),
            .pt     (in_data[g*BLK_W +: BLK_W]),
            .tw     (in_tweak[g*BLK_W +: BLK_W]),
            .rk     (round_key),
            .ct     (lane_ct)
        );
        assign out_data[g*BLK_W +: BLK_W] = lane_ct;
    end

endmodule

// File: rtl/xts_multilane_enc_chk.sv
module xts_multilane_enc_chk #(
    parameter int LANES = 4,
    parameter int NR    = 14,
    localparam int IDX_W = $clog2(NR + 1),
    localparam int BUS_W = LANES * 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [IDX_W-1:0] key_idx,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_data
);

    a_r7_busy_blocks_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r5_first_round_idx: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (key_idx == IDX_W'(1)));

    a_r5_idx_steps: assert property (@(posedge clk) disable iff (rst)
        (key_idx != '0 && key_idx != IDX_W'(NR)) |=> (key_idx == $past(key_idx) + 1'b1));

    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        key_idx <= IDX_W'(NR));

    a_r6_valid_after_last_round: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(key_idx, 2) == IDX_W'(NR)));

    a_r9_ready_after_take: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

bind xts_multilane_enc xts_multilane_enc_chk #(.LANES(LANES), .NR(NR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .key_idx   (key_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_xts_multilane_enc.sv
module sim_xts_multilane_enc;

    localparam int LANES = 4;
    localparam int BUS_W = LANES * 128;
    localparam logic [127:0] P_KAT = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C_KAT = 128'h8ea2b7ca516745bfeafc49904b496089;
    localparam logic [255:0] K_KAT = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    localparam logic [127:0] T1 = 128'h0123456789abcdeffedcba9876543210;
    localparam logic [127:0] T2 = {128{1'b1}};
    localparam logic [127:0] T3 = 128'h80000000000000000000000000000001;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [BUS_W-1:0] in_data = '0;
    logic [BUS_W-1:0] in_tweak = '0;
    logic [3:0]       key_idx;
    logic [127:0]     round_key;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [BUS_W-1:0] out_data;

    logic [7:0]   sb [256];
    logic [127:0] rkeys [16];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign round_key = rkeys[key_idx];

    xts_multilane_enc #(.LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_tweak(in_tweak), .key_idx(key_idx),
        .round_key(round_key), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rl(input logic [7:0] b, input int k);
        return (b << k) | (b >> (8 - k));
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    task automatic build_tables();
        logic [7:0]  p, q, x, rc;
        logic [31:0] w [60];
        logic [31:0] t;
        p = 8'h01;
        q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
        for (int i = 0; i < 8; i++) w[i] = K_KAT[255-32*i -: 32];
        rc = 8'h01;
        for (int i = 8; i < 60; i++) begin
            t = w[i-1];
            if (i % 8 == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
            end else if (i % 8 == 4) begin
                t = subw(t);
            end
            w[i] = w[i-8] ^ t;
        end
        for (int r = 0; r < 15; r++) rkeys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
        rkeys[15] = '0;
    endtask

    // one batch: plaintext P^T per lane so that each lane must return C^T
    task automatic run_batch(input logic [BUS_W-1:0] tws, input bit poke, input string tag);
        logic [BUS_W-1:0] held;
        int first_valid;
        int idx_bad;
        int ready_bad;
        first_valid = -1;
        idx_bad = 0;
        ready_bad = 0;
        held = '0;
        @(negedge clk);
        for (int i = 0; i < LANES; i++) in_data[i*128 +: 128] = P_KAT ^ tws[i*128 +: 128];
        in_tweak = tws;
        in_valid = 1'b1;
        chk(in_ready == 1'b1, {"R7 idle before ", tag}, 128'(in_ready), 128'd1);
        chk(key_idx == 4'd0, {"R5 idx zero at accept ", tag}, 128'(key_idx), 128'd0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int j = 0; j <= 17; j++) begin
            if (j > 0) @(negedge clk);
            if (j <= 14 && key_idx != ((j <= 13) ? 4'(j + 1) : 4'd0)) idx_bad++;
            if (in_ready) ready_bad++;
            if (out_valid && first_valid < 0) first_valid = j;
            if (j == 15) held = out_data;
            if (poke && j == 3) begin
                in_valid = 1'b1;
                in_data  = ~in_data;
                in_tweak = {BUS_W{1'b1}} ^ in_tweak;
            end
            if (poke && j == 6) in_valid = 1'b0;
        end
        chk(idx_bad == 0, {"R5 round index sequence ", tag}, 128'(idx_bad), 128'd0);
        chk(first_valid == 15, {"R6 latency ", tag}, 128'(first_valid), 128'd15);
        chk(ready_bad == 0, {"R7 ready low while busy ", tag}, 128'(ready_bad), 128'd0);
        chk(out_valid && out_data == held, {"R8 hold under backpressure ", tag},
            out_data[127:0], held[127:0]);
        for (int i = 0; i < LANES; i++) begin
            chk(out_data[i*128 +: 128] == (C_KAT ^ tws[i*128 +: 128]),
                $sformatf("R2 R4 lane %0d ciphertext %s", i, tag),
                out_data[i*128 +: 128], C_KAT ^ tws[i*128 +: 128]);
            if (tws[i*128 +: 128] == '0)
                chk(out_data[i*128 +: 128] == C_KAT, $sformatf("R3 R10 zero tweak lane %0d %s", i, tag),
                    out_data[i*128 +: 128], C_KAT);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready == 1'b1 && out_valid == 1'b0, {"R9 release ", tag},
            {126'd0, in_ready, out_valid}, 128'd2);
    endtask

    task automatic check_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'd1);
        chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'd0);
        chk(key_idx == 4'd0, "R1 key_idx", 128'(key_idx), 128'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        build_tables();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_reset();
        run_batch({T3, T2, T1, 128'd0}, 1'b0, "batch A");
        run_batch({T1, 128'd0, T2, T3}, 1'b1, "batch B ignored poke");
        run_batch({128'd0, 128'd0, 128'd0, 128'd0}, 1'b0, "batch C all zero tweaks");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule